// File: doc/BRIEF.md
# Infix to Postfix Token Reorderer

This block accepts an arithmetic expression as a stream of byte tokens in ordinary written (infix) order and sends the same tokens out in postfix order, which is the order a stack-based evaluator consumes. Each token carries a tag bit. A clear tag marks an unsigned integer operand byte. A set tag marks an operator, a bracket or the end-of-expression marker. Operands leave in the order they arrived. Operators are held on an internal stack and released so that exponentiation binds tightest, multiplication binds next, and addition and subtraction bind loosest. Brackets override this order and never appear on the output.

Both streams use a valid/ready handshake. When the end marker arrives, every operator still held is released, and then the marker itself goes out. After that the block accepts the next expression. Two sticky flags report faults: one for brackets that do not balance, and one for a push into a full operator stack. Each flag stays set until reset. The stack depth is a parameter.

Top module: `pfx_reorder`

## Requirements
- R1: After synchronous active-high reset, out_valid is 0, both error flags are 0, and in_ready is 1.
- R2: Token encoding on both sides. Tag 0 means an operand, and any byte value including 0xFF passes through unchanged and in arrival order. Tag 1 with 0x01 means add, 0x02 subtract, 0x03 multiply, 0x04 power, 0x05 opening bracket, 0x06 closing bracket and 0xFF end marker. Any other tag-1 byte is accepted and dropped.
- R3: Power is released before multiplication, and multiplication before addition and subtraction. For example, 3+4*2 gives 3 4 2 * +.
- R4: Add, subtract and multiply associate to the left, so 8-3-2 gives 8 3 - 2 -. Power associates to the right, so 2^3^2 gives 2 3 2 ^ ^.
- R5: Brackets group sub-expressions at any position and at any nesting depth, and no bracket code ever appears on the output.
- R6: On the end marker, all held operators are released, most recent first. Then 0xFF with tag 1 is emitted. An empty expression yields only the marker.
- R7: While out_valid is 1 and out_ready is 0, out_tag and out_data hold steady. Backpressure loses and duplicates no token.
- R8: A closing bracket with no matching opening bracket sets err_bracket. That bracket is dropped after the operators above it are released.
- R9: An opening bracket still unmatched at the end marker sets err_bracket and is discarded without output.
- R10: A push into a full stack (DEPTH entries) sets err_overflow and drops the pushed item. Exactly DEPTH held entries raises no flag.
- R11: Both error flags remain set until reset, across later expressions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input token present |
| in_ready | output | 1 | Input token taken this cycle |
| in_tag | input | 1 | 1 = operator/bracket/end code, 0 = operand |
| in_data | input | 8 | Token byte |
| out_valid | output | 1 | Output token present |
| out_ready | input | 1 | Downstream takes output token |
| out_tag | output | 1 | 1 = operator or end code, 0 = operand |
| out_data | output | 8 | Token byte |
| err_bracket | output | 1 | Sticky unbalanced-bracket flag |
| err_overflow | output | 1 | Sticky operator-stack overflow flag |

## Verification
The bench builds the block with DEPTH set to 4 instead of the default 16. With that depth, five opening brackets in a row are enough to hit the overflow path. The expression (((1+2))) fills the stack to exactly its capacity without raising the flag. The same small depth also lets the flush path discard several leftover opening brackets in a short run, and one expression is repeated under a stalling output to compare the token order.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam logic [7:0] CODE_ADD   = 8'h01;
    localparam logic [7:0] CODE_SUB   = 8'h02;
    localparam logic [7:0] CODE_MUL   = 8'h03;
    localparam logic [7:0] CODE_POW   = 8'h04;
    localparam logic [7:0] CODE_OPEN  = 8'h05;
    localparam logic [7:0] CODE_CLOSE = 8'h06;
    localparam logic [7:0] CODE_END   = 8'hFF;

    typedef enum logic [2:0] {
        K_NONE, K_ADD, K_SUB, K_MUL, K_POW, K_OPEN, K_CLOSE, K_END
    } kind_e;

    typedef enum logic [1:0] {
        PH_TAKE, PH_REDUCE, PH_CLOSE, PH_FLUSH
    } phase_e;

    typedef struct packed {
        logic       is_op;
        logic [7:0] value;
    } token_t;

    function automatic kind_e classify(logic [7:0] b);
        case (b)
            CODE_ADD:   return K_ADD;
            CODE_SUB:   return K_SUB;
            CODE_MUL:   return K_MUL;
            CODE_POW:   return K_POW;
            CODE_OPEN:  return K_OPEN;
            CODE_CLOSE: return K_CLOSE;
            CODE_END:   return K_END;
            default:    return K_NONE;
        endcase
    endfunction

    function automatic logic [7:0] encode(kind_e k);
        case (k)
            K_ADD:   return CODE_ADD;
            K_SUB:   return CODE_SUB;
            K_MUL:   return CODE_MUL;
            K_POW:   return CODE_POW;
            K_OPEN:  return CODE_OPEN;
            K_CLOSE: return CODE_CLOSE;
            K_END:   return CODE_END;
            default: return 8'h00;
        endcase
    endfunction

    // Binding strength; zero for anything that is not arithmetic.
    function automatic logic [1:0] rank(kind_e k);
        case (k)
            K_ADD, K_SUB: return 2'd1;
            K_MUL:        return 2'd2;
            K_POW:        return 2'd3;
            default:      return 2'd0;
        endcase
    endfunction

    function automatic logic binds_right(kind_e k);
        return k == K_POW;
    endfunction

    // True when the held operator must leave before the incoming one is stacked.
    function automatic logic yields(kind_e held, kind_e incoming);
        if (rank(held) == 2'd0) return 1'b0;
        if (rank(held) > rank(incoming)) return 1'b1;
        return (rank(held) == rank(incoming)) && !binds_right(incoming);
    endfunction

endpackage

// File: rtl/pfx_op_stack.sv
module pfx_op_stack
    import pfx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  logic  pop,
    input  kind_e push_kind,
    output kind_e top_kind,
    output logic  empty,
    output logic  full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    kind_e          slots [DEPTH];
    logic [CW-1:0]  count_q;
    logic [AW-1:0]  top_idx;

    assign empty   = (count_q == '0);
    assign full    = (count_q == CW'(DEPTH));
    assign top_idx = AW'(count_q - CW'(1));
    assign top_kind = empty ? K_NONE : slots[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (push && !full) begin
            slots[AW'(count_q)] <= push_kind;
            count_q <= count_q + CW'(1);
        end else if (pop && !empty) begin
            count_q <= count_q - CW'(1);
        end
    end
endmodule

// File: rtl/pfx_out_slot.sv
module pfx_out_slot
    import pfx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  token_t load_tok,
    input  logic   out_ready,
    output logic   out_valid,
    output token_t out_tok,
    output logic   free
);
    assign free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_tok   <= '0;
        end else if (load && free) begin
            out_valid <= 1'b1;
            out_tok   <= load_tok;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pfx_reorder.sv
module pfx_reorder
    import pfx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_tag,
    input  logic [7:0] in_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_tag,
    output logic [7:0] out_data,
    output logic       err_bracket,
    output logic       err_overflow
);
    phase_e ph_q, ph_d;
    kind_e  pend_q, pend_d;
    kind_e  in_kind, stk_top, push_kind;
    logic   stk_empty, stk_full, push, pop;
    logic   emit, out_free, set_brk, set_ovf;
    token_t emit_tok, out_tok;

    assign in_kind = classify(in_data);

    pfx_op_stack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst(rst), .push(push), .pop(pop), .push_kind(push_kind),
        .top_kind(stk_top), .empty(stk_empty), .full(stk_full)
    );

    pfx_out_slot u_out (
        .clk(clk), .rst(rst), .load(emit), .load_tok(emit_tok),
        .out_ready(out_ready), .out_valid(out_valid), .out_tok(out_tok),
        .free(out_free)
    );

    assign out_tag  = out_tok.is_op;
    assign out_data = out_tok.value;

    always_comb begin
        ph_d      = ph_q;
        pend_d    = pend_q;
        in_ready  = 1'b0;
        push      = 1'b0;
        pop       = 1'b0;
        push_kind = K_NONE;
        emit      = 1'b0;
        emit_tok  = '0;
        set_brk   = 1'b0;
        set_ovf   = 1'b0;
        case (ph_q)
            PH_TAKE: begin
                if (!in_tag) begin
                    in_ready = out_free;
                    if (in_valid && out_free) begin
                        emit     = 1'b1;
                        emit_tok = '{is_op: 1'b0, value: in_data};
                    end
                end else begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        case (in_kind)
                            K_OPEN: begin
                                if (stk_full) set_ovf = 1'b1;
                                else begin
                                    push      = 1'b1;
                                    push_kind = K_OPEN;
                                end
                            end
                            K_CLOSE: ph_d = PH_CLOSE;
                            K_END:   ph_d = PH_FLUSH;
                            K_ADD, K_SUB, K_MUL, K_POW: begin
                                pend_d = in_kind;
                                ph_d   = PH_REDUCE;
                            end
                            default: ;
                        endcase
                    end
                end
            end
            PH_REDUCE: begin
                if (!stk_empty && yields(stk_top, pend_q)) begin
                    if (out_free) begin
                        emit     = 1'b1;
                        emit_tok = '{is_op: 1'b1, value: encode(stk_top)};
                        pop      = 1'b1;
                    end
                end else begin
                    if (stk_full) set_ovf = 1'b1;
                    else begin
                        push      = 1'b1;
                        push_kind = pend_q;
                    end
                    ph_d = PH_TAKE;
                end
            end
            PH_CLOSE: begin
                if (stk_empty) begin
                    set_brk = 1'b1;
                    ph_d    = PH_TAKE;
                end else if (stk_top == K_OPEN) begin
                    pop  = 1'b1;
                    ph_d = PH_TAKE;
                end else if (out_free) begin
                    emit     = 1'b1;
                    emit_tok = '{is_op: 1'b1, value: encode(stk_top)};
                    pop      = 1'b1;
                end
            end
            PH_FLUSH: begin
                if (stk_empty) begin
                    if (out_free) begin
                        emit     = 1'b1;
                        emit_tok = '{is_op: 1'b1, value: CODE_END};
                        ph_d     = PH_TAKE;
                    end
                end else if (stk_top == K_OPEN) begin
                    pop     = 1'b1;
                    set_brk = 1'b1;
                end else if (out_free) begin
                    emit     = 1'b1;
                    emit_tok = '{is_op: 1'b1, value: encode(stk_top)};
                    pop      = 1'b1;
                end
            end
            default: ph_d = PH_TAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q         <= PH_TAKE;
            pend_q       <= K_NONE;
            err_bracket  <= 1'b0;
            err_overflow <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            pend_q <= pend_d;
            if (set_brk) err_bracket  <= 1'b1;
            if (set_ovf) err_overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/pfx_reorder_chk.sv
module pfx_reorder_chk (
    input logic       clk,
    input logic       rst,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_tag,
    input logic [7:0] out_data,
    input logic       err_bracket,
    input logic       err_overflow,
    input logic       stk_full
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !err_bracket && !err_overflow));

    assert_legal_codes_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_tag) |-> (out_data inside {8'h01, 8'h02, 8'h03, 8'h04, 8'hFF}));

    assert_no_bracket_out_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_tag) |-> !(out_data inside {8'h05, 8'h06}));

    assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));

    assert_overflow_needs_full_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overflow) |-> $past(stk_full));

    assert_bracket_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        err_bracket |=> err_bracket);

    assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        err_overflow |=> err_overflow);
endmodule

bind pfx_reorder pfx_reorder_chk u_chk (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
    .out_tag(out_tag), .out_data(out_data), .err_bracket(err_bracket),
    .err_overflow(err_overflow), .stk_full(stk_full)
);

// File: tb/sim_pfx_reorder.sv
module sim_pfx_reorder;
    localparam logic [8:0] T_ADD = 9'h101, T_SUB = 9'h102, T_MUL = 9'h103,
                           T_POW = 9'h104, T_OPN = 9'h105, T_CLS = 9'h106,
                           T_END = 9'h1FF;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 1'b0, in_tag = 1'b0, out_ready = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, out_valid, out_tag, err_bracket, err_overflow;
    logic [7:0] out_data;

    int n_run = 0, n_fail = 0;
    bit finished = 0;
    logic [8:0] src_q[$], exp_q[$], got_q[$];

    always #5 clk = ~clk;

    pfx_reorder #(.DEPTH(4)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_tag(out_tag), .out_data(out_data),
        .err_bracket(err_bracket), .err_overflow(err_overflow)
    );

    function automatic logic [8:0] V(int x);
        return {1'b0, 8'(x)};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic sender();
        foreach (src_q[i]) begin
            @(negedge clk);
            in_valid = 1'b1;
            {in_tag, in_data} = src_q[i];
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic collector(int stall);
        int cyc = 0;
        bit done = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            out_ready = (stall == 0) ? 1'b1 : ((cyc % 3) == 2);
            cyc++;
            #1;
            if (out_valid && out_ready) begin
                got_q.push_back({out_tag, out_data});
                if ({out_tag, out_data} == T_END) done = 1;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic run_expr(string req, int stall);
        got_q.delete();
        fork
            sender();
            collector(stall);
        join
        check({req, " length"}, 16'(got_q.size()), 16'(exp_q.size()));
        foreach (exp_q[i]) begin
            if (i < got_q.size()) check(req, 16'(got_q[i]), 16'(exp_q[i]));
            else check(req, 16'hDEAD, 16'(exp_q[i]));
        end
    endtask

    task automatic t_reset_R1();
        do_reset();
        #1;
        check("R1 out_valid", 16'(out_valid), 16'd0);
        check("R1 flags", 16'({err_bracket, err_overflow}), 16'd0);
        check("R1 in_ready", 16'(in_ready), 16'd1);
    endtask

    task automatic t_precedence_R3();
        do_reset();
        src_q = '{V(3), T_ADD, V(4), T_MUL, V(2), T_END};
        exp_q = '{V(3), V(4), V(2), T_MUL, T_ADD, T_END};
        run_expr("R3 3+4*2", 0);
        src_q = '{V(2), T_POW, V(2), T_MUL, V(3), T_SUB, V(1), T_END};
        exp_q = '{V(2), V(2), T_POW, V(3), T_MUL, V(1), T_SUB, T_END};
        run_expr("R3 2^2*3-1", 0);
    endtask

    task automatic t_assoc_R4();
        do_reset();
        src_q = '{V(8), T_SUB, V(3), T_SUB, V(2), T_END};
        exp_q = '{V(8), V(3), T_SUB, V(2), T_SUB, T_END};
        run_expr("R4 8-3-2", 0);
        src_q = '{V(2), T_POW, V(3), T_POW, V(2), T_END};
        exp_q = '{V(2), V(3), V(2), T_POW, T_POW, T_END};
        run_expr("R4 2^3^2", 0);
    endtask

    task automatic t_brackets_R5();
        do_reset();
        src_q = '{T_OPN, V(1), T_ADD, V(2), T_CLS, T_MUL, T_OPN, V(3), T_SUB, V(4), T_CLS, T_END};
        exp_q = '{V(1), V(2), T_ADD, V(3), V(4), T_SUB, T_MUL, T_END};
        run_expr("R5 (1+2)*(3-4)", 0);
        src_q = '{V(2), T_MUL, T_OPN, T_OPN, V(3), T_ADD, V(4), T_CLS, T_POW, V(2), T_CLS, T_END};
        exp_q = '{V(2), V(3), V(4), T_ADD, V(2), T_POW, T_MUL, T_END};
        run_expr("R5 nested", 0);
        check("R5 no bracket flag", 16'(err_bracket), 16'd0);
    endtask

    task automatic t_passthrough_R2();
        do_reset();
        src_q = '{V(255), T_ADD, 9'h140, V(0), T_END};
        exp_q = '{V(255), V(0), T_ADD, T_END};
        run_expr("R2 operand FF and unknown code", 0);
    endtask

    task automatic t_end_R6();
        do_reset();
        src_q = '{T_END};
        exp_q = '{T_END};
        run_expr("R6 empty", 0);
        src_q = '{V(1), T_ADD, V(2), T_MUL, V(3), T_POW, V(4), T_END};
        exp_q = '{V(1), V(2), V(3), V(4), T_POW, T_MUL, T_ADD, T_END};
        run_expr("R6 flush order", 0);
    endtask

    task automatic t_stall_R7();
        do_reset();
        src_q = '{T_OPN, V(5), T_SUB, V(6), T_CLS, T_POW, V(7), T_ADD, V(9), T_END};
        exp_q = '{V(5), V(6), T_SUB, V(7), T_POW, V(9), T_ADD, T_END};
        run_expr("R7 backpressure", 1);
    endtask

    task automatic t_close_R8();
        do_reset();
        src_q = '{V(1), T_ADD, V(2), T_CLS, T_MUL, V(3), T_END};
        exp_q = '{V(1), V(2), T_ADD, V(3), T_MUL, T_END};
        run_expr("R8 stray close", 0);
        check("R8 flag", 16'(err_bracket), 16'd1);
        check("R8 no overflow", 16'(err_overflow), 16'd0);
    endtask

    task automatic t_open_R9();
        do_reset();
        src_q = '{T_OPN, V(1), T_ADD, V(2), T_END};
        exp_q = '{V(1), V(2), T_ADD, T_END};
        run_expr("R9 stray open", 0);
        check("R9 flag", 16'(err_bracket), 16'd1);
    endtask

    task automatic t_overflow_R10();
        do_reset();
        src_q = '{T_OPN, T_OPN, T_OPN, V(1), T_ADD, V(2), T_CLS, T_CLS, T_CLS, T_END};
        exp_q = '{V(1), V(2), T_ADD, T_END};
        run_expr("R10 exactly full", 0);
        check("R10 full no flag", 16'({err_overflow, err_bracket}), 16'd0);
        src_q = '{T_OPN, T_OPN, T_OPN, T_OPN, T_OPN, V(7), T_END};
        exp_q = '{V(7), T_END};
        run_expr("R10 overflow", 0);
        check("R10 flag", 16'(err_overflow), 16'd1);
        // R11: flags persist across a clean expression
        src_q = '{V(4), T_MUL, V(5), T_END};
        exp_q = '{V(4), V(5), T_MUL, T_END};
        run_expr("R11 after errors", 0);
        check("R11 sticky", 16'({err_overflow, err_bracket}), 16'h3);
        do_reset();
        #1;
        check("R11 cleared by reset", 16'({err_overflow, err_bracket}), 16'd0);
    endtask

    initial begin
        t_reset_R1();
        t_precedence_R3();
        t_assoc_R4();
        t_brackets_R5();
        t_passthrough_R2();
        t_end_R6();
        t_stall_R7();
        t_close_R8();
        t_open_R9();
        t_overflow_R10();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule